// File: doc/BRIEF.md
# PRBS Word Generator with Frame Overlay

The block produces a pseudo-random binary sequence as 16-bit words, one word per clock. A 2-bit length select picks one of four primitive polynomials. The polynomial is latched when the generator starts, so the sequence length in use only changes after the generator is seeded again. Seeding is done through an initialization input. That input must stay high for a minimum number of clocks. While it is high, the shift register fills with ones. When it is released, the generator starts. If it is released too early, the generator stays silent.

A sync output gives a one-clock pulse with the word that carries the final bit of each full sequence period. Bits are counted modulo the selected period length, so the pulse drifts across word boundaries from one period to the next.

An optional framed mode replaces the bytes at the head of each fixed-length frame of words with SONET/SDH framing bytes. A run of A1 bytes comes first, then a run of A2 bytes. The generator keeps advancing underneath those bytes, so the random data resumes exactly where it would have been without the frame.

Top module: `prbs_word_gen`

## Requirements
- R1: After a synchronous reset, and until a valid seeding, `word_out` is 0 and `sync_out` is 0.
- R2: Seeding works as follows:
  - `init_in` must be sampled high on at least INIT_HOLD (default 32) consecutive clocks and then sampled low.
  - On that low clock the generator starts.
  - The first word appears on the following clock.
  - A shorter high run leaves the outputs at 0.
- R3: Seeding loads an all-ones history. With select 00 (2^7-1) the first word is therefore 16'h020C.
- R4: The length select codes map as follows:
  - 00 gives x^7+x^6+1.
  - 01 gives x^15+x^14+1.
  - 10 gives x^23+x^18+1.
  - 11 gives x^31+x^28+1.
  - In each case the new bit equals bit(t-deg) XOR bit(t-tap).
  - The sequence repeats after 2^deg-1 bits, so word n+(2^deg-1) equals word n.
- R5: Each clock emits the next 16 sequence bits. The earliest bit is in word_out[15] and the latest is in word_out[0]. There are no gaps between consecutive words.
- R6: `sync_out` is high for exactly one clock, together with the word that holds bit number k*(2^deg-1)-1 (bits counted from 0 after seeding). A full run of 2^deg-1 words therefore contains exactly 16 pulses, and no two pulses are adjacent.
- R7: A change of `len_sel` while running has no effect until the next seeding.
- R8: With `frame_en` high, the framing bytes overwrite the head of every frame:
  - Output words are grouped into frames of FRAME_WORDS words (default 24), starting with the first word after seeding.
  - Bytes are numbered from the frame start, with the upper byte of each word first.
  - The first A1_CNT bytes (default 4) become 8'hF6.
  - The next A2_CNT bytes (default 4) become 8'h28.
- R9: In framed mode, every byte that is not overwritten equals the byte that the unframed sequence has at that position, and `sync_out` is unchanged.
- R10: With `frame_en` low, no byte is overwritten.
- R11: Raising `init_in` while running forces the outputs to 0 from the next clock. A later valid release restarts the sequence from its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 2 | Sequence length select, latched at start |
| init_in | input | 1 | Seeding request, must be held for INIT_HOLD clocks |
| frame_en | input | 1 | Overlay framing bytes at each frame head |
| word_out | output | 16 | Registered sequence word, earliest bit in MSB |
| sync_out | output | 1 | Registered end-of-period pulse |

## Verification
The following properties are checked on every clock by assertions:
- The outputs stay silent while the generator is idle.
- A sync pulse is never followed by another and only appears after a running clock.
- The latched length is stable across a run.
- A frame head in framed mode always carries the A1 byte.

Some behaviours can only be shown by the bench scenarios, which compare every word against a bit-level recurrence model:
- the exact bit sequence of each polynomial;
- the period repeat;
- the 31/32-clock seeding boundary;
- the number of sync pulses per full period;
- the placement of the framing bytes;
- the continuity of the data underneath them.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int unsigned STATE_W = 31;
  localparam int unsigned NUM_POLY = 4;

  typedef enum logic [1:0] {
    LEN_P7  = 2'd0,
    LEN_P15 = 2'd1,
    LEN_P23 = 2'd2,
    LEN_P31 = 2'd3
  } prbs_len_e;

  function automatic int unsigned poly_degree(input logic [1:0] s);
    case (s)
      2'd0:    return 7;
      2'd1:    return 15;
      2'd2:    return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int unsigned poly_tap(input logic [1:0] s);
    case (s)
      2'd0:    return 6;
      2'd1:    return 14;
      2'd2:    return 18;
      default: return 28;
    endcase
  endfunction

  function automatic logic [31:0] period_bits(input logic [1:0] s);
    return (32'd1 << poly_degree(s)) - 32'd1;
  endfunction

endpackage

// File: rtl/prbs_init_ctl.sv
module prbs_init_ctl
  import prbs_pkg::*;
#(
  parameter int unsigned HOLD = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      init_in,
  input  prbs_len_e len_sel,
  output logic      running,
  output prbs_len_e sel_q
);

  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      running  <= 1'b0;
      sel_q    <= LEN_P7;
    end else if (init_in) begin
      running <= 1'b0;
      if (hold_cnt != HOLD_C) begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end else begin
      hold_cnt <= '0;
      if (hold_cnt == HOLD_C) begin
        running <= 1'b1;
        sel_q   <= len_sel;
      end
    end
  end

endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              load,
  input  logic              advance,
  input  prbs_len_e         sel,
  output logic [WORD_W-1:0] step_bits
);

  logic [STATE_W-1:0] state_q;
  logic [NUM_POLY-1:0][STATE_W-1:0] nxt_all;
  logic [NUM_POLY-1:0][WORD_W-1:0]  bits_all;

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    localparam int unsigned DEG = poly_degree(2'(g));
    localparam int unsigned TAP = poly_tap(2'(g));

    logic [STATE_W-1:0] loc_nxt;
    logic [WORD_W-1:0]  loc_bits;

    always_comb begin
      logic [STATE_W-1:0] s;
      logic fb;
      s = state_q;
      loc_bits = '0;
      for (int i = 0; i < WORD_W; i++) begin
        fb = s[DEG-1] ^ s[TAP-1];
        loc_bits[WORD_W-1-i] = fb;
        s = {s[STATE_W-2:0], fb};
      end
      loc_nxt = s;
    end

    assign nxt_all[g]  = loc_nxt;
    assign bits_all[g] = loc_bits;
  end

  assign step_bits = bits_all[sel];

  always_ff @(posedge clk) begin
    if (load) begin
      state_q <= '1;
    end else if (advance) begin
      state_q <= nxt_all[sel];
    end
  end

endmodule

// File: rtl/prbs_period_cnt.sv
module prbs_period_cnt
  import prbs_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic      clk,
  input  logic      clear,
  input  logic      advance,
  input  prbs_len_e sel,
  output logic      wrap
);

  localparam logic [31:0] STEP = 32'(WORD_W);

  logic [31:0] pos_q;
  logic [31:0] sum;
  logic [31:0] period;
  logic [31:0] pos_nxt;

  always_comb begin
    period  = period_bits(sel);
    sum     = pos_q + STEP;
    wrap    = (sum >= period);
    pos_nxt = wrap ? (sum - period) : sum;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      pos_q <= '0;
    end else if (advance) begin
      pos_q <= pos_nxt;
    end
  end

endmodule

// File: rtl/prbs_frame_overlay.sv
module prbs_frame_overlay #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned FRAME_WORDS = 24,
  parameter int unsigned A1_CNT      = 4,
  parameter int unsigned A2_CNT      = 4,
  parameter logic [7:0]  A1_BYTE     = 8'hF6,
  parameter logic [7:0]  A2_BYTE     = 8'h28
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              advance,
  input  logic [WORD_W-1:0] prbs_bits,
  output logic [WORD_W-1:0] framed_bits,
  output logic              frame_head
);

  localparam int unsigned BYTES = WORD_W / 8;
  localparam int unsigned FW_W  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [FW_W-1:0] LAST_IDX = FW_W'(FRAME_WORDS - 1);

  logic [FW_W-1:0] idx_q;

  always_comb begin
    int unsigned bi;
    framed_bits = prbs_bits;
    for (int j = 0; j < BYTES; j++) begin
      bi = int'(idx_q) * BYTES + j;
      if (bi < A1_CNT) begin
        framed_bits[WORD_W-1-8*j -: 8] = A1_BYTE;
      end else if (bi < A1_CNT + A2_CNT) begin
        framed_bits[WORD_W-1-8*j -: 8] = A2_BYTE;
      end
    end
  end

  assign frame_head = (idx_q == '0);

  always_ff @(posedge clk) begin
    if (clear) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned INIT_HOLD   = 32,
  parameter int unsigned FRAME_WORDS = 24,
  parameter int unsigned A1_CNT      = 4,
  parameter int unsigned A2_CNT      = 4,
  parameter logic [7:0]  A1_BYTE     = 8'hF6,
  parameter logic [7:0]  A2_BYTE     = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        len_sel,
  input  logic              init_in,
  input  logic              frame_en,
  output logic [WORD_W-1:0] word_out,
  output logic              sync_out
);

  logic              running;
  prbs_len_e         sel_q;
  logic              seed_load;
  logic              advance;
  logic [WORD_W-1:0] step_bits;
  logic [WORD_W-1:0] framed_bits;
  logic              wrap;
  logic              frame_head;

  assign seed_load = rst | init_in;
  assign advance   = running & ~init_in;

  prbs_init_ctl #(.HOLD(INIT_HOLD)) u_init (
    .clk     (clk),
    .rst     (rst),
    .init_in (init_in),
    .len_sel (prbs_len_e'(len_sel)),
    .running (running),
    .sel_q   (sel_q)
  );

  prbs_lfsr_core #(.WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .load      (seed_load),
    .advance   (advance),
    .sel       (sel_q),
    .step_bits (step_bits)
  );

  prbs_period_cnt #(.WORD_W(WORD_W)) u_period (
    .clk     (clk),
    .clear   (seed_load),
    .advance (advance),
    .sel     (sel_q),
    .wrap    (wrap)
  );

  prbs_frame_overlay #(
    .WORD_W      (WORD_W),
    .FRAME_WORDS (FRAME_WORDS),
    .A1_CNT      (A1_CNT),
    .A2_CNT      (A2_CNT),
    .A1_BYTE     (A1_BYTE),
    .A2_BYTE     (A2_BYTE)
  ) u_frame (
    .clk         (clk),
    .clear       (seed_load),
    .advance     (advance),
    .prbs_bits   (step_bits),
    .framed_bits (framed_bits),
    .frame_head  (frame_head)
  );

  always_ff @(posedge clk) begin
    if (rst || !advance) begin
      word_out <= '0;
      sync_out <= 1'b0;
    end else begin
      word_out <= frame_en ? framed_bits : step_bits;
      sync_out <= wrap;
    end
  end

endmodule

// File: rtl/prbs_word_gen_chk.sv
module prbs_word_gen_chk #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned A1_CNT  = 4,
  parameter logic [7:0]  A1_BYTE = 8'hF6
) (
  input logic              clk,
  input logic              rst,
  input logic              init_in,
  input logic              frame_en,
  input logic [WORD_W-1:0] word_out,
  input logic              sync_out,
  input logic              running,
  input logic [1:0]        sel_q,
  input logic              frame_head
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> (word_out == '0 && !sync_out));

  // R11
  init_stops_chk: assert property (@(posedge clk) disable iff (rst)
    init_in |=> (!running && word_out == '0));

  // R6
  sync_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out);

  // R6
  sync_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> $past(running));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> $stable(sel_q));

  // R8
  frame_a1_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !init_in && frame_en && frame_head && (A1_CNT > 0))
      |=> (word_out[WORD_W-1 -: 8] == A1_BYTE));

endmodule

bind prbs_word_gen prbs_word_gen_chk #(
  .WORD_W  (WORD_W),
  .A1_CNT  (A1_CNT),
  .A1_BYTE (A1_BYTE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .init_in    (init_in),
  .frame_en   (frame_en),
  .word_out   (word_out),
  .sync_out   (sync_out),
  .running    (running),
  .sel_q      (sel_q),
  .frame_head (frame_head)
);

// File: tb/prbs_word_gen_test.sv
`timescale 1ns/1ps
module prbs_word_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  len_sel = 2'd0;
  logic        init_in = 1'b0;
  logic        frame_en = 1'b0;
  logic [15:0] word_out;
  logic        sync_out;

  int total = 0;
  int bad = 0;
  string cur_tag = "R5";

  // reference model state
  bit          m_run = 0;
  int          m_cnt = 0;
  logic [1:0]  m_sel = 2'd0;
  bit          hist[$];
  longint      m_bits = 0;
  int          m_fidx = 0;
  logic [15:0] e_word = 0;
  bit          e_sync = 0;
  bit          e_valid = 0;
  logic [15:0] got_q[$];
  bit          sync_q[$];
  logic [15:0] ref_q[$];

  always #4 clk = ~clk;

  prbs_word_gen uut (
    .clk      (clk),
    .rst      (rst),
    .len_sel  (len_sel),
    .init_in  (init_in),
    .frame_en (frame_en),
    .word_out (word_out),
    .sync_out (sync_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int deg_of(logic [1:0] s);
    case (s)
      2'd0: return 7;
      2'd1: return 15;
      2'd2: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int tap_of(logic [1:0] s);
    case (s)
      2'd0: return 6;
      2'd1: return 14;
      2'd2: return 18;
      default: return 28;
    endcase
  endfunction

  task automatic model_step();
    e_valid = 0;
    if (rst) begin
      m_run = 0; m_cnt = 0; e_word = 0; e_sync = 0;
    end else if (init_in) begin
      m_run = 0; e_word = 0; e_sync = 0;
      if (m_cnt < 32) m_cnt++;
    end else if (!m_run) begin
      e_word = 0; e_sync = 0;
      if (m_cnt >= 32) begin
        m_run = 1; m_sel = len_sel;
        hist.delete();
        repeat (31) hist.push_back(1'b1);
        m_bits = 0; m_fidx = 0;
      end
      m_cnt = 0;
    end else begin
      int n;
      int k;
      longint per;
      n = deg_of(m_sel);
      k = tap_of(m_sel);
      per = (longint'(1) << n) - 1;
      e_sync = 0;
      for (int i = 0; i < 16; i++) begin
        bit b;
        b = hist[hist.size() - n] ^ hist[hist.size() - k];
        hist.push_back(b);
        if (hist.size() > 40) void'(hist.pop_front());
        e_word[15-i] = b;
        if (((m_bits + i + 1) % per) == 0) e_sync = 1;
      end
      m_bits += 16;
      if (frame_en) begin
        for (int j = 0; j < 2; j++) begin
          int bi;
          bi = m_fidx * 2 + j;
          if (bi < 4) e_word[15-8*j -: 8] = 8'hF6;
          else if (bi < 8) e_word[15-8*j -: 8] = 8'h28;
        end
      end
      m_fidx = (m_fidx + 1) % 24;
      e_valid = 1;
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #2;
    check(cur_tag, 32'(word_out), 32'(e_word));
    check("R6", 32'(sync_out), 32'(e_sync));
    if (e_valid) begin
      got_q.push_back(word_out);
      sync_q.push_back(sync_out);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_init(int hold, logic [1:0] s);
    @(negedge clk);
    init_in = 1'b1;
    len_sel = s;
    got_q.delete();
    sync_q.delete();
    repeat (hold) @(negedge clk);
    init_in = 1'b0;
  endtask

  function automatic int count_sync(int upto);
    int c;
    c = 0;
    for (int i = 0; i < upto; i++) if (sync_q[i]) c++;
    return c;
  endfunction

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", 32'(word_out), 32'h0);
    check("R1 reset sync", 32'(sync_out), 32'h0);
    cycles(6);
    check("R1 idle without seeding", 32'(word_out), 32'h0);

    // R2 short hold of 31 clocks leaves the generator silent
    cur_tag = "R2";
    do_init(31, 2'd0);
    cycles(10);
    check("R2 short hold word", 32'(word_out), 32'h0);
    check("R2 short hold no words", 32'(got_q.size()), 32'h0);

    // R2/R3/R4/R5/R6 select 00
    cur_tag = "R5";
    do_init(32, 2'd0);
    cycles(2);
    check("R2 started after 32 clocks", 32'(got_q.size() > 0), 32'h1);
    cycles(260);
    check("R3 first word from all-ones seed", 32'(got_q[0]), 32'h020C);
    check("R4 period 127 repeat", 32'(got_q[127]), 32'(got_q[0]));
    check("R4 period 127 repeat second", 32'(got_q[130]), 32'(got_q[3]));
    check("R6 sync count over 127 words", 32'(count_sync(127)), 32'd16);
    ref_q = got_q;

    // R10 unframed head words carry no framing bytes
    check("R10 word0 not framed", 32'(got_q[0] == 16'hF6F6), 32'h0);
    check("R10 word2 not framed", 32'(got_q[2] == 16'h2828), 32'h0);

    // R11 seeding request mid-run silences output
    cur_tag = "R11";
    @(negedge clk);
    init_in = 1'b1;
    @(negedge clk);
    check("R11 output cleared", 32'(word_out), 32'h0);
    cycles(40);
    init_in = 1'b0;
    got_q.delete();
    sync_q.delete();
    cycles(5);
    check("R11 restart first word", 32'(got_q[0]), 32'h020C);

    // R4 select 01 full period, R7 select change ignored
    cur_tag = "R4";
    do_init(32, 2'd1);
    cycles(1000);
    begin
      int bad_before;
      bad_before = bad;
      cur_tag = "R7";
      len_sel = 2'd3;
      cycles(500);
      check("R7 select change ignored", 32'(bad - bad_before), 32'h0);
    end
    cur_tag = "R4";
    cycles(31300);
    check("R4 period 32767 repeat", 32'(got_q[32767]), 32'(got_q[0]));
    check("R6 sync count over 32767 words", 32'(count_sync(32767)), 32'd16);

    // R4 selects 10 and 11 against the model
    do_init(32, 2'd2);
    cycles(300);
    check("R4 select 10 words produced", 32'(got_q.size() > 250), 32'h1);
    do_init(40, 2'd3);
    cycles(300);
    check("R4 select 11 words produced", 32'(got_q.size() > 250), 32'h1);

    // R8/R9 framed mode
    cur_tag = "R8";
    frame_en = 1'b1;
    do_init(32, 2'd0);
    cycles(140);
    check("R8 word0 A1", 32'(got_q[0]), 32'hF6F6);
    check("R8 word1 A1", 32'(got_q[1]), 32'hF6F6);
    check("R8 word2 A2", 32'(got_q[2]), 32'h2828);
    check("R8 word3 A2", 32'(got_q[3]), 32'h2828);
    check("R8 next frame head", 32'(got_q[24]), 32'hF6F6);
    check("R8 next frame A2", 32'(got_q[27]), 32'h2828);
    check("R9 data resumes after frame", 32'(got_q[4]), 32'(ref_q[4]));
    check("R9 data before next frame", 32'(got_q[23]), 32'(ref_q[23]));
    check("R9 data after next frame", 32'(got_q[28]), 32'(ref_q[28]));
    check("R9 sync count unchanged", 32'(count_sync(127)), 32'd16);
    frame_en = 1'b0;
    cycles(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule